// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block resolves the two operand fields of an instruction for a 16-bit processor that has sixteen 16-bit registers. Each field is six bits wide. It names a register, an immediate word, a direct address or a pointer-based memory access. The source field sits in instruction bits 11..6 and the destination field in bits 5..0. After a one-cycle `start`, the sequencer handles the source field first and the destination field second.

For each field the sequencer does the following:
- It reads the register file through an asynchronous read port.
- It takes any extension word it needs from the instruction stream over a valid/ready handshake.
- It presents one result cycle. That cycle carries either an operand value, or a memory request with a byte/word qualifier. In the same cycle it can write back an advanced pointer and raise an illegal flag.

Field encoding:
- Bits 5..4 give the mode class: 00 register, 01 indirect, 10 indirect with post-increment, 11 indirect with index.
- For the pointer classes, bit 3 is the byte flag and bits 2..0 pick one of R8..R15.
- Two codes that would otherwise reach the stack pointer R15 are given other meanings. Code 01_1_111 means immediate. Codes 10_b_111 mean direct with byte flag b.
- A post-increment through R15 can therefore never occur.

Top module: `opnd_mode_seq`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `done`, `opr_valid`, `ext_ready`, `mem_req` and `rf_we` are all 0.
- R2: Register field 00_rrrr takes no extension word and raises no memory request. It returns the full 16-bit content of register rrrr on `opr_value`.
- R3: Immediate field 01_1_111 consumes exactly one extension word and returns that word on `opr_value`. It raises no memory request.
- R4: Direct field 10_b_111 consumes one extension word and requests memory at that address. `mem_byte` equals b, where 1 means a byte access and 0 means a word access.
- R5: Indirect field 01_b_ppp, excluding 01_1_111, requests memory at the content of register 8+ppp with `mem_byte`=b. It takes no extension word and writes no register.
- R6: Post-increment field 10_b_ppp with ppp≠111 requests memory at the old pointer value. In the same result cycle it writes the pointer plus 1 (byte) or plus 2 (word), modulo 2^16, back to register 8+ppp.
- R7: Indexed field 11_b_ppp, excluding 11_1_111, consumes one extension word. It requests memory at pointer plus word, modulo 2^16, and leaves the pointer register unchanged.
- R8: Field 11_1_111 (byte-wide indexed access through R15) raises `illegal` in its result cycle. It still consumes its extension word, and it raises no memory request and no register write.
- R9: The source result (`opr_dst`=0) comes before the destination result (`opr_dst`=1). Extension words are consumed in that same order, and exactly as many are consumed as the two fields need.
- R10: An extension word is taken only in a cycle where `ext_valid` and `ext_ready` are both high. While `ext_valid` stays low, the sequencer keeps waiting with `ext_ready` high.
- R11: `done` is a one-cycle pulse. It is raised only together with the destination result, after all extension words of the instruction have been consumed.
- R12: A `start` that arrives while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving `instr` (honoured only when idle) |
| instr | input | 12 | Source field [11:6], destination field [5:0] |
| ext_valid | input | 1 | Extension word available |
| ext_data | input | 16 | Extension word |
| ext_ready | output | 1 | Sequencer is waiting for an extension word |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 16 | Register file read data (same cycle) |
| rf_we | output | 1 | Pointer write-back enable |
| rf_waddr | output | 4 | Pointer write-back register |
| rf_wdata | output | 16 | Updated pointer value |
| opr_valid | output | 1 | Result cycle for one field |
| opr_dst | output | 1 | 0: source result, 1: destination result |
| opr_value | output | 16 | Operand value for register and immediate fields, else 0 |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 16 | Effective address |
| mem_byte | output | 1 | 1 byte access, 0 word access |
| illegal | output | 1 | Field combination is rejected |
| done | output | 1 | Instruction fully resolved |

## Verification
The hardest situation to reach is a pair of fields that interact. One case is a source post-increment followed by a destination that reads or increments the same pointer, which must see the advanced value. Another is a pair of extension-word fields whose words must be matched to the right operand while `ext_valid` stalls at random. Directed cases pin these down, including a pointer that wraps from 0xFFFF, the R15 codes and the illegal byte index. Seeded random instructions then mix all field classes, random register contents, random handshake gaps and a stray `start` in mid-instruction. A bench-side register model tracks every write-back.

// File: rtl/opnd_pkg.sv
// Shared widths and types for the operand addressing mode sequencer.
// Assumes a 16-bit datapath, sixteen registers and 6-bit operand fields.
package opnd_pkg;
    parameter int DW  = 16;   // data and address width
    parameter int RAW = 4;    // register index width
    parameter int FW  = 6;    // operand field width

    localparam int IW = 2 * FW;  // width of the two-field instruction slice

    typedef enum logic [2:0] {
        MD_REG,
        MD_IMM,
        MD_DIR,
        MD_IND,
        MD_INC,
        MD_IDX
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [RAW-1:0]   reg_sel;
        logic             byte_acc;
        logic             need_ext;
        logic             bad;
    } field_t;
endpackage

// File: rtl/opnd_field_decode.sv
// Combinational decode of one 6-bit operand field.
// Bits 5..4 select the class. Pointer classes use bit 3 as the byte flag and
// bits 2..0 as the pointer index into R8..R15. Two stack-pointer codes are
// given other meanings: 01_1_111 is immediate and 10_x_111 is direct.
// Assumes the field is stable while it is being decoded.
module opnd_field_decode
    import opnd_pkg::*;
(
    input  logic [FW-1:0] fld,
    output field_t        dec
);
    localparam logic [2:0] SP_LOW = 3'b111;

    logic sp_ptr;
    assign sp_ptr = (fld[2:0] == SP_LOW);

    // Map the class bits and the stack-pointer special codes to a mode.
    always_comb begin
        dec          = '0;
        dec.mode     = MD_REG;
        dec.reg_sel  = {1'b1, fld[2:0]};
        dec.byte_acc = fld[3];
        dec.need_ext = 1'b0;
        dec.bad      = 1'b0;
        case (fld[5:4])
            2'b00: begin
                dec.mode     = MD_REG;
                dec.reg_sel  = fld[RAW-1:0];
                dec.byte_acc = 1'b0;
            end
            2'b01: begin
                if (fld[3] && sp_ptr) begin
                    dec.mode     = MD_IMM;
                    dec.need_ext = 1'b1;
                    dec.byte_acc = 1'b0;
                end else begin
                    dec.mode = MD_IND;
                end
            end
            2'b10: begin
                if (sp_ptr) begin
                    dec.mode     = MD_DIR;
                    dec.need_ext = 1'b1;
                end else begin
                    dec.mode = MD_INC;
                end
            end
            default: begin
                dec.mode     = MD_IDX;
                dec.need_ext = 1'b1;
                dec.bad      = fld[3] && sp_ptr;
            end
        endcase
    end
endmodule

// File: rtl/opnd_addr_gen.sv
// Combinational operand and address formation for one decoded field.
// It produces the operand value for register and immediate modes, the
// effective address for memory modes, and the advanced pointer for
// post-increment. Assumes ptr and ext are already captured in registers.
module opnd_addr_gen
    import opnd_pkg::*;
(
    input  mode_e         mode,
    input  logic          byte_acc,
    input  logic [DW-1:0] ptr,
    input  logic [DW-1:0] ext,
    output logic [DW-1:0] value,
    output logic [DW-1:0] addr,
    output logic [DW-1:0] next_ptr,
    output logic          is_mem,
    output logic          wb
);
    logic [DW-1:0] step;

    // Post-increment step is 1 for a byte access and 2 for a word access.
    assign step     = {{(DW-2){1'b0}}, ~byte_acc, byte_acc};
    assign next_ptr = ptr + step;

    // Select the value or the address that the mode calls for.
    always_comb begin
        value  = '0;
        addr   = '0;
        is_mem = 1'b0;
        wb     = 1'b0;
        case (mode)
            MD_REG: value = ptr;
            MD_IMM: value = ext;
            MD_DIR: begin addr = ext;       is_mem = 1'b1; end
            MD_IND: begin addr = ptr;       is_mem = 1'b1; end
            MD_INC: begin addr = ptr;       is_mem = 1'b1; wb = 1'b1; end
            MD_IDX: begin addr = ptr + ext; is_mem = 1'b1; end
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/opnd_mode_seq.sv
// Operand addressing mode sequencer (top).
// After start it resolves the source field (instr[11:6]) and then the
// destination field (instr[5:0]). Each field passes through DECODE (register
// read), then EXTWORD if an extension word is needed, then RESULT (one cycle
// of outputs). Assumes a register file with a same-cycle read and a write
// that lands at the clock edge that ends the RESULT cycle.
module opnd_mode_seq
    import opnd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [11:0]     instr,
    input  logic            ext_valid,
    input  logic [15:0]     ext_data,
    output logic            ext_ready,
    output logic [3:0]      rf_raddr,
    input  logic [15:0]     rf_rdata,
    output logic            rf_we,
    output logic [3:0]      rf_waddr,
    output logic [15:0]     rf_wdata,
    output logic            opr_valid,
    output logic            opr_dst,
    output logic [15:0]     opr_value,
    output logic            mem_req,
    output logic [15:0]     mem_addr,
    output logic            mem_byte,
    output logic            illegal,
    output logic            done
);
    typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_EXTWORD, ST_RESULT} state_e;

    state_e        st;
    logic          fsel;
    logic [IW-1:0] instr_q;
    logic [DW-1:0] ptr_q;
    logic [DW-1:0] ext_q;

    logic [FW-1:0] fld;
    field_t        dec;
    logic [DW-1:0] ag_value, ag_addr, ag_next;
    logic          ag_mem, ag_wb, in_res;

    // Pick the field under work: the source first, then the destination.
    assign fld = fsel ? instr_q[FW-1:0] : instr_q[IW-1:FW];

    opnd_field_decode u_dec (
        .fld (fld),
        .dec (dec)
    );

    opnd_addr_gen u_agen (
        .mode     (dec.mode),
        .byte_acc (dec.byte_acc),
        .ptr      (ptr_q),
        .ext      (ext_q),
        .value    (ag_value),
        .addr     (ag_addr),
        .next_ptr (ag_next),
        .is_mem   (ag_mem),
        .wb       (ag_wb)
    );

    // Sequence the two fields and capture the register and extension data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            fsel    <= 1'b0;
            instr_q <= '0;
            ptr_q   <= '0;
            ext_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        instr_q <= instr;
                        fsel    <= 1'b0;
                        st      <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    ptr_q <= rf_rdata;
                    st    <= dec.need_ext ? ST_EXTWORD : ST_RESULT;
                end
                ST_EXTWORD: begin
                    if (ext_valid) begin
                        ext_q <= ext_data;
                        st    <= ST_RESULT;
                    end
                end
                default: begin
                    if (!fsel) begin
                        fsel <= 1'b1;
                        st   <= ST_DECODE;
                    end else begin
                        st   <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Drive the outputs of the RESULT cycle; all are zero in other cycles.
    always_comb begin
        in_res    = (st == ST_RESULT);
        ext_ready = (st == ST_EXTWORD);
        rf_raddr  = dec.reg_sel;
        opr_valid = in_res;
        opr_dst   = in_res && fsel;
        opr_value = in_res ? ag_value : '0;
        illegal   = in_res && dec.bad;
        mem_req   = in_res && ag_mem && !dec.bad;
        mem_addr  = mem_req ? ag_addr : '0;
        mem_byte  = mem_req && dec.byte_acc;
        rf_we     = in_res && ag_wb && !dec.bad;
        rf_waddr  = rf_we ? dec.reg_sel : '0;
        rf_wdata  = rf_we ? ag_next : '0;
        done      = in_res && fsel;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !done && !ext_ready && !mem_req && !rf_we); // R1
    AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (DW'(rf_wdata - mem_addr) == (mem_byte ? DW'(1) : DW'(2)))); // R6
    AST_WB_NOT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr[RAW-1] && rf_waddr != 4'hF)); // R6
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !rf_we)); // R8
    AST_SRC_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (opr_valid && !opr_dst) |=> !opr_valid); // R9
    AST_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ready && !ext_valid) |=> ext_ready); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_WITH_DST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (opr_valid && opr_dst && !ext_ready)); // R11
endmodule

// File: tb/sim_opnd_mode_seq.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random instructions.
module sim_opnd_mode_seq;
    logic        clk = 1'b0;
    logic        rst_n, start, ext_valid;
    logic [11:0] instr;
    logic [15:0] ext_data, rf_rdata, rf_wdata, opr_value, mem_addr;
    logic [3:0]  rf_raddr, rf_waddr;
    logic        ext_ready, rf_we, opr_valid, opr_dst, mem_req, mem_byte, illegal, done;

    always #10 clk = ~clk;   // 50 MHz

    int nchk = 0;
    int nfail = 0;
    int ext_cnt = 0;
    logic [15:0] regs [16];
    logic [15:0] pool [256];
    logic        poke_en = 1'b0;
    logic        seed_en = 1'b0;
    logic [3:0]  poke_idx = '0;
    logic [15:0] poke_val = '0;

    opnd_mode_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ext_valid(ext_valid), .ext_data(ext_data), .ext_ready(ext_ready),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .opr_valid(opr_valid),
        .opr_dst(opr_dst), .opr_value(opr_value), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_byte(mem_byte), .illegal(illegal), .done(done)
    );

    assign rf_rdata = regs[rf_raddr];
    assign ext_data = pool[ext_cnt % 256];

    // Register file model and extension-word counter.
    always @(posedge clk) begin
        if (seed_en)
            for (int i = 0; i < 16; i++) regs[i] <= 16'($urandom);
        else if (poke_en)
            regs[poke_idx] <= poke_val;
        else if (rf_we)
            regs[rf_waddr] <= rf_wdata;
        if (ext_valid && ext_ready) ext_cnt <= ext_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit need_ext(input logic [5:0] f);
        return (f[5:4] == 2'b01 && f[3:0] == 4'hF) || (f[5:4] == 2'b10 && f[2:0] == 3'b111)
               || (f[5:4] == 2'b11);
    endfunction

    function automatic string tag(input logic [5:0] f);
        case (f[5:4])
            2'b00:   return "R2";
            2'b01:   return (f[3:0] == 4'hF) ? "R3" : "R5";
            2'b10:   return (f[2:0] == 3'b111) ? "R4" : "R6";
            default: return (f[3:0] == 4'hF) ? "R8" : "R7";
        endcase
    endfunction

    // Expected result vector {mem, addr, byte, we, waddr, wdata, illegal, value}.
    function automatic logic [55:0] expect_res(input logic [5:0] f, input logic [15:0] ew);
        logic [15:0] p, addr, wdata, val;
        logic        mem, byt, we, ill;
        logic [3:0]  wa;
        p = regs[{1'b1, f[2:0]}];
        {addr, wdata, val} = '0; {mem, byt, we, ill} = '0; wa = '0;
        case (f[5:4])
            2'b00: val = regs[f[3:0]];
            2'b01: if (f[3:0] == 4'hF) val = ew;
                   else begin mem = 1; addr = p; byt = f[3]; end
            2'b10: if (f[2:0] == 3'b111) begin mem = 1; addr = ew; byt = f[3]; end
                   else begin
                       mem = 1; addr = p; byt = f[3]; we = 1; wa = {1'b1, f[2:0]};
                       wdata = p + (f[3] ? 16'd1 : 16'd2);
                   end
            default: if (f[3:0] == 4'hF) ill = 1;
                     else begin mem = 1; addr = p + ew; byt = f[3]; end
        endcase
        return {mem, addr, byt, we, wa, wdata, ill, val};
    endfunction

    task automatic poke(input logic [3:0] idx, input logic [15:0] v);
        @(negedge clk); poke_en = 1; poke_idx = idx; poke_val = v;
        @(negedge clk); poke_en = 0;
    endtask

    task automatic run_op(input logic [11:0] ins, input bit inject, input int vprob);
        int base, nres, nsrc, k;
        bit bad_done;
        logic [55:0] act, exp;
        logic [5:0]  f;
        base = ext_cnt; nres = 0; bad_done = 0;
        nsrc = need_ext(ins[11:6]) ? 1 : 0;
        @(negedge clk); start = 1; instr = ins;
        @(negedge clk); start = 0;
        for (int c = 0; c < 200 && nres < 2; c++) begin
            if (inject && c == 1) begin start = 1; instr = ~ins; end
            else start = 0;
            if (done && !(opr_valid && opr_dst)) bad_done = 1;
            if (opr_valid) begin
                f = opr_dst ? ins[5:0] : ins[11:6];
                k = opr_dst ? nsrc : 0;
                exp = expect_res(f, pool[(base + k) % 256]);
                act = {mem_req, mem_req ? mem_addr : 16'h0, mem_req & mem_byte, rf_we,
                       rf_we ? rf_waddr : 4'h0, rf_we ? rf_wdata : 16'h0, illegal, opr_value};
                chk(act == exp, tag(f), 64'(act), 64'(exp));
                chk(opr_dst == (nres == 1), "R9 order", 64'(opr_dst), 64'(nres == 1));
                chk(done == opr_dst, "R11 done", 64'(done), 64'(opr_dst));
                nres++;
            end
            ext_valid = ($urandom_range(99) < vprob);
            @(negedge clk);
        end
        start = 0; ext_valid = 0;
        chk(nres == 2, "R10 completion", 64'(nres), 64'd2);
        chk(ext_cnt - base == nsrc + (need_ext(ins[5:0]) ? 1 : 0), "R9 ext count",
            64'(ext_cnt - base), 64'(nsrc + (need_ext(ins[5:0]) ? 1 : 0)));
        chk(!bad_done, "R11 stray done", 64'(bad_done), 64'd0);
        if (inject) begin
            @(negedge clk);
            chk(!opr_valid && !ext_ready, "R12 start ignored", 64'({opr_valid, ext_ready}), 64'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 256; i++) pool[i] = 16'($urandom);
        for (int i = 0; i < 16; i++) regs[i] = 16'(i * 16'h1111);
        rst_n = 0; start = 0; instr = '0; ext_valid = 0;
        repeat (3) @(negedge clk);
        chk({done, opr_valid, ext_ready, mem_req, rf_we} == 5'b0, "R1 in reset",
            64'({done, opr_valid, ext_ready, mem_req, rf_we}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk({done, opr_valid, ext_ready, mem_req, rf_we} == 5'b0, "R1 after reset",
            64'({done, opr_valid, ext_ready, mem_req, rf_we}), 64'd0);

        poke(4'd9, 16'h1000); poke(4'd15, 16'hFFFF);
        poke(4'd3, 16'hBEEF); poke(4'd12, 16'h2001);
        run_op({6'b00_0011, 6'b01_1111}, 0, 100);   // R2 register, R3 immediate
        run_op({6'b10_0111, 6'b10_1111}, 0, 40);    // R4 direct word then byte
        run_op({6'b01_0001, 6'b01_1111}, 0, 30);    // R5 indirect word, immediate
        run_op({6'b01_1100, 6'b01_0111}, 0, 100);   // R5 byte via R12, word via R15
        run_op({6'b10_0001, 6'b10_0001}, 0, 100);   // R6 same pointer twice
        chk(regs[9] == 16'h1004, "R6 double step", 64'(regs[9]), 64'h1004);
        poke(4'd10, 16'hFFFF);
        run_op({6'b10_1010, 6'b00_1010}, 0, 100);   // R6 byte wrap, read back
        run_op({6'b11_0100, 6'b11_1111}, 0, 50);    // R7 index, R8 illegal
        chk(regs[12] == 16'h2001, "R7 pointer kept", 64'(regs[12]), 64'h2001);
        run_op({6'b11_1111, 6'b11_0111}, 1, 25);    // R8 then R7 via R15, R12 inject
        poke(4'd8, 16'hFFF0);
        run_op({6'b11_0000, 6'b10_0000}, 0, 60);    // R7 wrap, R6 word

        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) begin
                @(negedge clk); seed_en = 1; @(negedge clk); seed_en = 0;
            end
            run_op(12'($urandom), ($urandom_range(7) == 0), 30 + $urandom_range(70));
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule